// File: doc/BRIEF.md
# Peak-and-Hold Solenoid Injection Sequencer

This block runs one solenoid injection cycle at a time for a current-controlled injector driver. A rising injection command first passes through a digital deglitch filter. It then starts a peak phase: the excitation switch and the recirculation switch are both on, and the external DAC multiplexer is pointed at the peak reference. Once the current comparator reports that the peak level has been reached, the block enters a hold phase. In the hold phase the excitation switch is chopped by a fixed-period PWM, and the reference drops to the hold level, or to a reduced hold level while a thermal warning is present. When the command falls, both switches open in the same cycle and a clamp flag marks the demagnetization window, which lasts for a programmed number of cycles.

The overcurrent comparator is looked at only in the peak phase, and only after a blanking window that follows each turn-on of the excitation switch. The same window masks the current comparator. A trip opens both switches and latches an active-low fault output. The fault stays latched until a clear strobe arrives, and injection commands are ignored meanwhile.

Four parameters can be written through a simple write port fed by a serial bus engine: the peak level, the hold level, the reduced hold level and the demagnetization length. These values are staged and then snapshotted when the transaction ends. They are applied only at the start of the next injection, so a cycle already running never sees a change.

Top module: `pkh_seq`

## Requirements
- R1: The raw command `inj_cmd` is acted on only after it has held a new level for `FILT_CYC` consecutive clock samples. A pulse of fewer samples does not start a cycle.
- R2: A filtered rising command while idle, with no fault latched, enters the peak phase one cycle after the filter accepts it. In this phase `s1_on`=1, `s2_on`=1, `ref_sel`=2'b01 and `dac_level` is the active peak level.
- R3: For the first `BLANK_CYC` cycles after the excitation switch turns on, `cur_hit` and `oc_hit` have no effect. The turn-on events are peak entry and each hold PWM period start.
- R4: In the peak phase, `cur_hit`=1 after blanking moves the block to the hold phase. In the hold phase `ref_sel`=2'b10 with the hold level on `dac_level`, or `ref_sel`=2'b11 with the reduced hold level while `temp_warn`=1.
- R5: In the hold phase `s2_on` stays 1. `s1_on` turns on at the start of every `PWM_PERIOD`-cycle period and turns off the cycle after `cur_hit` is seen after blanking. This gives `BLANK_CYC`+1 on-cycles per period under a constant hit, and `PWM_PERIOD` on-cycles with no hit.
- R6: `oc_hit`=1 in the peak phase after blanking makes the next cycle show `s1_on`=0, `s2_on`=0 and `fault_n`=0. `oc_hit` has no effect in the hold phase.
- R7: The fault stays latched until `fault_clr` is sampled high. While it is latched, injection commands start nothing. After the clear the block is idle with `fault_n`=1 and waits for a new rising command.
- R8: A filtered falling command in the peak or hold phase sets `s1_on`=0 and `s2_on`=0 in the same cycle and raises `clamp_flag`. `clamp_flag` stays high for the programmed demagnetization count (at least one cycle), after which the block is idle.
- R9: Writes land in a staging bank by `wr_addr`: 0 is the peak level, 1 the hold level, 2 the reduced hold level and 3 the demagnetization count. A `bus_done` pulse snapshots the staging bank. The snapshot becomes active only at the next cycle start. After reset the active values are 0xC8, 0x50, 0x3C and 16.
- R10: After reset and while idle, `s1_on`=0, `s2_on`=0, `ref_sel`=2'b00, `dac_level`=0, `clamp_flag`=0 and `fault_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_cmd | input | 1 | Raw injection command |
| cur_hit | input | 1 | Current comparator: load current at or above selected reference |
| oc_hit | input | 1 | Overcurrent comparator |
| temp_warn | input | 1 | Thermal warning, selects reduced hold reference |
| fault_clr | input | 1 | Clears a latched fault |
| wr_en | input | 1 | Parameter write strobe |
| wr_addr | input | 2 | Parameter index |
| wr_data | input | 8 | Parameter value |
| bus_done | input | 1 | End-of-transaction pulse |
| s1_on | output | 1 | Excitation switch command |
| s2_on | output | 1 | Recirculation switch command |
| ref_sel | output | 2 | Reference select code for the DAC multiplexer |
| dac_level | output | 8 | Level for the selected reference |
| clamp_flag | output | 1 | Demagnetization clamp active |
| fault_n | output | 1 | Active-low latched fault |

## Verification
Command pulses one sample short of the filter length and exactly at that length separate a filter that is off by one from a correct one. A design that is off by one starts on a glitch or drops a valid command. Comparator and overcurrent inputs are held active from the first peak cycle, and the phase is checked at cycle `BLANK_CYC` and at the cycle after it. A design with a wrong blanking window leaves the peak phase or trips one cycle early or late, and the same window sets the per-period PWM on-count. Parameters are written before a transaction ends and again in the middle of a cycle, and then the next cycle is checked. A design without proper shadowing shows new levels too early or loses them. Overcurrent is applied during the hold phase and commands are raised during a latched fault. A design that mishandles these faults from the hold phase or restarts before the clear.

// File: rtl/pkh_pkg.sv
package pkh_pkg;
  localparam int PAR_W    = 8;
  localparam int PAR_NUM  = 4;
  localparam int ADDR_W   = $clog2(PAR_NUM);
  localparam int PAR_PEAK  = 0;
  localparam int PAR_HOLD  = 1;
  localparam int PAR_HOT   = 2;
  localparam int PAR_DEMAG = 3;

  localparam logic [PAR_W-1:0] DEF_PEAK  = 8'hC8;
  localparam logic [PAR_W-1:0] DEF_HOLD  = 8'h50;
  localparam logic [PAR_W-1:0] DEF_HOT   = 8'h3C;
  localparam logic [PAR_W-1:0] DEF_DEMAG = 8'h10;

  localparam logic [1:0] REF_NONE = 2'b00;
  localparam logic [1:0] REF_PEAK = 2'b01;
  localparam logic [1:0] REF_HOLD = 2'b10;
  localparam logic [1:0] REF_HOT  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PEAK, ST_HOLD, ST_CLAMP, ST_FAULT
  } phase_t;

  typedef logic [PAR_NUM-1:0][PAR_W-1:0] par_bank_t;

  function automatic par_bank_t par_defaults();
    par_bank_t b;
    b[PAR_PEAK]  = DEF_PEAK;
    b[PAR_HOLD]  = DEF_HOLD;
    b[PAR_HOT]   = DEF_HOT;
    b[PAR_DEMAG] = DEF_DEMAG;
    return b;
  endfunction
endpackage

// File: rtl/pkh_deglitch.sv
module pkh_deglitch #(
  parameter int FILT_CYC = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic rise,
  output logic fall
);
  localparam int CNT_W = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             rise_q, rise_d, fall_q, fall_d;

  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (raw == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
      cnt_d  = '0;
      lvl_d  = raw;
      rise_d = raw;
      fall_d = ~raw;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign rise = rise_q;
  assign fall = fall_q;

  AST_FILT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == lvl_q) |=> (!rise_q && !fall_q)) else $error("filter edge without change"); // R1
endmodule

// File: rtl/pkh_pwm.sv
module pkh_pwm #(
  parameter int PWM_PERIOD = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stop,
  output logic on,
  output logic wrap
);
  localparam int PW = $clog2(PWM_PERIOD);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          off_q, off_d;

  assign wrap = run && (cnt_q == PW'(PWM_PERIOD - 1));
  assign on   = run && !off_q;

  always_comb begin
    if (!run) begin
      cnt_d = '0;
      off_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      off_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      off_d = off_q | stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      off_q <= off_d;
    end
  end

  AST_PWM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && run) |=> (on || !run)) else $error("pwm did not restart"); // R5
endmodule

// File: rtl/pkh_params.sv
module pkh_params
  import pkh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PAR_W-1:0]  wr_data,
  input  logic              bus_done,
  input  logic              apply,
  output par_bank_t         active
);
  par_bank_t stage_q, stage_d, ready_q, ready_d, act_q, act_d;
  logic      pend_q, pend_d;

  always_comb begin
    stage_d = stage_q;
    ready_d = ready_q;
    act_d   = act_q;
    pend_d  = pend_q;
    if (wr_en) stage_d[wr_addr] = wr_data;
    if (apply && pend_q) begin
      act_d  = ready_q;
      pend_d = 1'b0;
    end
    if (bus_done) begin
      ready_d = stage_d;
      pend_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= par_defaults();
      ready_q <= par_defaults();
      act_q   <= par_defaults();
      pend_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      ready_q <= ready_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
    end
  end

  assign active = act_q;

  AST_PAR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(act_q)) else $error("active parameters changed outside a start"); // R9
endmodule

// File: rtl/pkh_seq.sv
module pkh_seq
  import pkh_pkg::*;
#(
  parameter int FILT_CYC   = 800,
  parameter int BLANK_CYC  = 2000,
  parameter int PWM_PERIOD = 16000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inj_cmd,
  input  logic              cur_hit,
  input  logic              oc_hit,
  input  logic              temp_warn,
  input  logic              fault_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PAR_W-1:0]  wr_data,
  input  logic              bus_done,
  output logic              s1_on,
  output logic              s2_on,
  output logic [1:0]        ref_sel,
  output logic [PAR_W-1:0]  dac_level,
  output logic              clamp_flag,
  output logic              fault_n
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  phase_t           state_q, state_d;
  logic [BW-1:0]    bcnt_q, bcnt_d;
  logic [PAR_W-1:0] dcnt_q, dcnt_d;
  logic             cmd_rise, cmd_fall;
  logic             blank_ok, start, pwm_on, pwm_wrap, demag_done;
  logic [PAR_W:0]   dcnt_inc;
  par_bank_t        par;

  pkh_deglitch #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw(inj_cmd), .rise(cmd_rise), .fall(cmd_fall)
  );

  assign start = (state_q == ST_IDLE) && cmd_rise;

  pkh_params u_par (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_done(bus_done), .apply(start), .active(par)
  );

  assign blank_ok = (bcnt_q == BW'(BLANK_CYC));

  pkh_pwm #(.PWM_PERIOD(PWM_PERIOD)) u_pwm (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_HOLD),
    .stop(cur_hit && blank_ok), .on(pwm_on), .wrap(pwm_wrap)
  );

  assign dcnt_inc   = {1'b0, dcnt_q} + 1'b1;
  assign demag_done = dcnt_inc >= {1'b0, par[PAR_DEMAG]};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_rise) state_d = ST_PEAK;
      ST_PEAK: begin
        if (blank_ok && oc_hit)       state_d = ST_FAULT;
        else if (cmd_fall)            state_d = ST_CLAMP;
        else if (blank_ok && cur_hit) state_d = ST_HOLD;
      end
      ST_HOLD:  if (cmd_fall) state_d = ST_CLAMP;
      ST_CLAMP: if (demag_done) state_d = ST_IDLE;
      ST_FAULT: if (fault_clr) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (start || pwm_wrap)         bcnt_d = '0;
    else if (!blank_ok)            bcnt_d = bcnt_q + 1'b1;
    else                           bcnt_d = bcnt_q;
    dcnt_d = (state_q == ST_CLAMP) ? dcnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      dcnt_q  <= dcnt_d;
    end
  end

  assign s1_on      = (state_q == ST_PEAK) || ((state_q == ST_HOLD) && pwm_on);
  assign s2_on      = (state_q == ST_PEAK) || (state_q == ST_HOLD);
  assign clamp_flag = (state_q == ST_CLAMP);
  assign fault_n    = (state_q != ST_FAULT);

  always_comb begin
    ref_sel   = REF_NONE;
    dac_level = '0;
    if (state_q == ST_PEAK) begin
      ref_sel   = REF_PEAK;
      dac_level = par[PAR_PEAK];
    end else if (state_q == ST_HOLD) begin
      ref_sel   = temp_warn ? REF_HOT : REF_HOLD;
      dac_level = temp_warn ? par[PAR_HOT] : par[PAR_HOLD];
    end
  end

  AST_START_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cmd_rise) |=> (s1_on && s2_on && ref_sel == REF_PEAK)) else $error("no peak start"); // R2
  AST_PEAK_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEAK && !blank_ok) |=> (state_q == ST_PEAK || state_q == ST_CLAMP)) else $error("acted inside blanking"); // R3
  AST_OC_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEAK && blank_ok && oc_hit) |=> (!fault_n && !s1_on && !s2_on)) else $error("overcurrent not tripped"); // R6
  AST_OC_HOLD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> fault_n) else $error("fault from hold"); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !fault_clr) |=> !fault_n) else $error("fault released"); // R7
  AST_FALL_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && cmd_fall) |=> (!s1_on && !s2_on && clamp_flag)) else $error("fall did not open switches"); // R8
endmodule

// File: tb/pkh_seq_test.sv
`timescale 1ns/1ps
module pkh_seq_test;
  localparam int FILT = 4;
  localparam int BLNK = 5;
  localparam int PER  = 16;

  logic clk, rst_n, inj_cmd, cur_hit, oc_hit, temp_warn, fault_clr;
  logic wr_en, bus_done;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic s1_on, s2_on, clamp_flag, fault_n;
  logic [1:0] ref_sel;
  logic [7:0] dac_level;

  int checks = 0, fails = 0, cyc = 0;
  logic saw_s1;

  pkh_seq #(.FILT_CYC(FILT), .BLANK_CYC(BLNK), .PWM_PERIOD(PER)) uut (
    .clk(clk), .rst_n(rst_n), .inj_cmd(inj_cmd), .cur_hit(cur_hit), .oc_hit(oc_hit),
    .temp_warn(temp_warn), .fault_clr(fault_clr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bus_done(bus_done), .s1_on(s1_on), .s2_on(s2_on),
    .ref_sel(ref_sel), .dac_level(dac_level), .clamp_flag(clamp_flag), .fault_n(fault_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (s1_on) saw_s1 <= 1'b1;
    if (cyc > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // {pulse length in samples, expect a cycle to start}
  localparam int NV = 4;
  localparam logic [8:0] VEC [NV] = '{ {8'd1, 1'b0}, {8'd3, 1'b0}, {8'd4, 1'b1}, {8'd7, 1'b1} };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    bus_done = 1'b1;
    tick();
    bus_done = 1'b0;
  endtask

  task automatic clamp_len(output int n);
    n = 0;
    while (clamp_flag && n < 300) begin
      n++;
      tick();
    end
  endtask

  initial begin
    int n, hi;
    logic s2_all;
    rst_n = 1'b0; inj_cmd = 1'b0; cur_hit = 1'b0; oc_hit = 1'b0; temp_warn = 1'b0;
    fault_clr = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; bus_done = 1'b0;
    saw_s1 = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk("R10 s1", s1_on, 0); chk("R10 s2", s2_on, 0); chk("R10 ref", ref_sel, 0);
    chk("R10 dac", dac_level, 0); chk("R10 clamp", clamp_flag, 0); chk("R10 fault_n", fault_n, 1);

    // R1 glitch table
    for (int v = 0; v < NV; v++) begin
      saw_s1 = 1'b0;
      inj_cmd = 1'b1;
      repeat (int'(VEC[v][8:1])) tick();
      inj_cmd = 1'b0;
      repeat (60) tick();
      chk($sformatf("R1 pulse len %0d", VEC[v][8:1]), saw_s1, VEC[v][0]);
      chk("R1 back to idle", clamp_flag | s2_on, 0);
    end

    // R2..R5 main cycle with defaults
    cur_hit = 1'b1;
    inj_cmd = 1'b1;
    repeat (FILT) tick();
    chk("R2 not yet started", s1_on, 0);
    tick();
    chk("R2 s1", s1_on, 1); chk("R2 s2", s2_on, 1); chk("R2 ref", ref_sel, 2'b01);
    chk("R9 default peak", dac_level, 8'hC8);
    repeat (BLNK) tick();
    chk("R3 still peak at blank end", ref_sel, 2'b01);
    tick();
    chk("R4 hold ref", ref_sel, 2'b10); chk("R4 hold dac", dac_level, 8'h50);
    repeat (PER) tick();
    hi = 0; s2_all = 1'b1;
    for (int i = 0; i < PER; i++) begin
      if (s1_on) hi++;
      s2_all &= s2_on;
      tick();
    end
    chk("R5 on-cycles with hit", hi, BLNK + 1);
    chk("R5 s2 held", s2_all, 1);
    cur_hit = 1'b0;
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      if (s1_on) hi++;
      tick();
    end
    chk("R5 on-cycles without hit", hi, PER);
    temp_warn = 1'b1;
    tick();
    chk("R4 hot ref", ref_sel, 2'b11); chk("R4 hot dac", dac_level, 8'h3C);
    temp_warn = 1'b0;
    oc_hit = 1'b1;
    repeat (5) tick();
    chk("R6 oc ignored in hold", fault_n, 1); chk("R6 still hold", ref_sel, 2'b10);
    oc_hit = 1'b0;
    inj_cmd = 1'b0;
    repeat (FILT) tick();
    chk("R8 s2 before fall seen", s2_on, 1);
    tick();
    chk("R8 s1 off", s1_on, 0); chk("R8 s2 off", s2_on, 0); chk("R8 clamp", clamp_flag, 1);
    clamp_len(n);
    chk("R8 clamp length default", n, 16);
    chk("R10 idle ref", ref_sel, 0);

    // R9 shadowing
    wr(2'd0, 8'h90);
    inj_cmd = 1'b1;
    repeat (FILT + 1) tick();
    chk("R9 no done -> default peak", dac_level, 8'hC8);
    done_pulse();
    wr(2'd1, 8'h33);
    wr(2'd3, 8'd3);
    done_pulse();
    chk("R9 mid-cycle peak unchanged", dac_level, 8'hC8);
    cur_hit = 1'b1;
    repeat (2) tick();
    chk("R9 mid-cycle hold unchanged", dac_level, 8'h50);
    inj_cmd = 1'b0;
    repeat (FILT + 1 + 16 + 4) tick();
    cur_hit = 1'b0;
    inj_cmd = 1'b1;
    repeat (FILT + 1) tick();
    chk("R9 new peak applied", dac_level, 8'h90);
    cur_hit = 1'b1;
    repeat (BLNK + 2) tick();
    chk("R9 new hold applied", dac_level, 8'h33);
    inj_cmd = 1'b0;
    repeat (FILT + 1) tick();
    clamp_len(n);
    chk("R9 programmed clamp length", n, 3);
    cur_hit = 1'b0;

    // R6/R7 fault path
    oc_hit = 1'b1;
    inj_cmd = 1'b1;
    repeat (FILT + 1) tick();
    chk("R6 peak entered", s1_on, 1);
    repeat (BLNK) tick();
    chk("R3 oc blanked", fault_n, 1);
    tick();
    chk("R6 fault_n low", fault_n, 0); chk("R6 s1 off", s1_on, 0); chk("R6 s2 off", s2_on, 0);
    inj_cmd = 1'b0; oc_hit = 1'b0;
    repeat (10) tick();
    inj_cmd = 1'b1;
    repeat (FILT + 3) tick();
    chk("R7 command ignored in fault", s1_on, 0);
    chk("R7 fault sticky", fault_n, 0);
    fault_clr = 1'b1;
    tick();
    fault_clr = 1'b0;
    chk("R7 cleared", fault_n, 1);
    repeat (3) tick();
    chk("R7 no restart without new rise", s1_on, 0);
    inj_cmd = 1'b0;
    repeat (10) tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule